// File: doc/BRIEF.md
# Write-Protected Clock Control Block with System Clock Divider

This block is a small byte-wide register file that governs the system clock. It holds four registers: two main clock control registers, a status register and an oscillator control register. The second main control register also configures a built-in divider, which turns the base clock into a one-cycle clock-enable pulse at a programmable ratio. Downstream logic uses that pulse as its instruction-rate enable.

The three control registers are guarded by an unlock qualifier. A separate protection unit raises this qualifier for a short window after a key sequence. A write that arrives while the qualifier is low is discarded without any effect, and the register keeps its value. Reads are never gated. Read data is registered and appears one cycle after the read strobe.

The divider ratio comes from a sparse 4-bit code. Codes 0 to 5 give powers of two from 2 to 64. Codes 8 to 12 give 6, 10, 12, 24 and 48. Any other code gives 2. When the divider is switched off, the enable pulse is high on every base cycle. An accepted write to the divider register restarts the divider count, so the new ratio starts from a clean phase.

Top module: `protected_clock_ctl`

## Requirements
- R1: After reset, every register reads 0x00, the divider is off and `clkEn` is high on every cycle.
- R2: A write to offset 0x00 (main control A), 0x01 (divider control) or 0x08 (oscillator control) is stored only if `unlock` is high in the same cycle. Otherwise the register keeps its old value.
- R3: A read with `rdEn` high returns the register value one cycle later, whatever the state of `unlock`. In any cycle after one without `rdEn`, `rdData` is 0x00.
- R4: The status register at offset 0x02 always reads 0x00 and ignores every write, locked or unlocked. Its bit 0 is the oscillator-changing flag, and an accepted divider write leaves it clear.
- R5: Every other offset reads 0x00, and a write to it changes no register.
- R6: When divider control bit 0 (enable) is 0, the ratio is 1 and `clkEn` is high on every cycle.
- R7: With enable set, division code bits 4:1 equal to 0..5 give ratios 2, 4, 8, 16, 32 and 64.
- R8: With enable set, codes 8, 9, 10, 11 and 12 give ratios 6, 10, 12, 24 and 48.
- R9: With enable set, codes 6, 7, 13, 14 and 15 give ratio 2.
- R10: An accepted divider write restarts the count. With ratio N, `clkEn` is low for N-1 cycles after the write edge, then high for one cycle, and repeats with period N. This holds even when the write lands on a cycle where `clkEn` is high.
- R11: A locked write to the divider register leaves the `clkEn` cadence undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| unlock | input | 1 | Write qualifier from the protection unit |
| rdData | output | 8 | Registered read data |
| clkEn | output | 1 | Divided clock-enable pulse |

## Verification
The case that needs care is an accepted divider write that coincides with the divider's terminal count. In that cycle, the restart and the natural wrap both want to reset the counter, and the old and new ratios meet. The bench first runs the divider at ratio 4. It then issues an accepted write selecting ratio 8 on exactly the cycle where `clkEn` is high. From the write edge onward, it compares every cycle of `clkEn` against the pattern expected for ratio 8. A locked write placed mid-period is judged the same way against the unchanged old ratio.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int OFF_MAIN_A = 'h00;
  localparam int OFF_DIV    = 'h01;
  localparam int OFF_STATUS = 'h02;
  localparam int OFF_OSC    = 'h08;
  localparam int RATIO_W    = 7;

  typedef enum logic [2:0] {
    RS_ZERO, RS_MAIN, RS_DIV, RS_STATUS, RS_OSC
  } readSel_t;

  typedef struct packed {
    logic     loadMain;
    logic     loadDiv;
    logic     loadOsc;
    logic     readStb;
    readSel_t readSel;
  } ctlStrobes_t;

  function automatic logic [RATIO_W-1:0] divRatio(input logic enable, input logic [3:0] code);
    if (!enable) return RATIO_W'(1);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return RATIO_W'(2) << code;
      4'd8:  return RATIO_W'(6);
      4'd9:  return RATIO_W'(10);
      4'd10: return RATIO_W'(12);
      4'd11: return RATIO_W'(24);
      4'd12: return RATIO_W'(48);
      default: return RATIO_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              unlock,
  output ctlStrobes_t       strobes
);
  logic hitMain, hitDiv, hitStatus, hitOsc, wrOk;

  assign hitMain   = (addr == ADDR_W'(OFF_MAIN_A));
  assign hitDiv    = (addr == ADDR_W'(OFF_DIV));
  assign hitStatus = (addr == ADDR_W'(OFF_STATUS));
  assign hitOsc    = (addr == ADDR_W'(OFF_OSC));
  assign wrOk      = wrEn && unlock;

  always_comb begin
    strobes.loadMain = wrOk && hitMain;
    strobes.loadDiv  = wrOk && hitDiv;
    strobes.loadOsc  = wrOk && hitOsc;
    strobes.readStb  = rdEn;
    if (hitMain)        strobes.readSel = RS_MAIN;
    else if (hitDiv)    strobes.readSel = RS_DIV;
    else if (hitStatus) strobes.readSel = RS_STATUS;
    else if (hitOsc)    strobes.readSel = RS_OSC;
    else                strobes.readSel = RS_ZERO;
  end
endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  ctlStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData,
  output logic              clkEn
);
  logic [DATA_W-1:0]  mainReg, divReg, oscReg, rdMux;
  logic [RATIO_W-1:0] ratio, divCnt;
  logic               terminal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainReg <= '0;
      divReg  <= '0;
      oscReg  <= '0;
    end else begin
      if (strobes.loadMain) mainReg <= wrData;
      if (strobes.loadDiv)  divReg  <= wrData;
      if (strobes.loadOsc)  oscReg  <= wrData;
    end
  end

  assign ratio    = divRatio(divReg[0], divReg[4:1]);
  assign terminal = (divCnt == ratio - RATIO_W'(1));
  assign clkEn    = terminal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         divCnt <= '0;
    else if (strobes.loadDiv || terminal) divCnt <= '0;
    else                               divCnt <= divCnt + RATIO_W'(1);
  end

  always_comb begin
    case (strobes.readSel)
      RS_MAIN: rdMux = mainReg;
      RS_DIV:  rdMux = divReg;
      RS_OSC:  rdMux = oscReg;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strobes.readStb ? rdMux : '0;
  end
endmodule

// File: rtl/protected_clock_ctl.sv
module protected_clock_ctl
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              unlock,
  output logic [DATA_W-1:0] rdData,
  output logic              clkEn
);
  ctlStrobes_t strobes;

  pcc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .unlock(unlock), .strobes(strobes)
  );

  pcc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobes(strobes),
    .rdData(rdData), .clkEn(clkEn)
  );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrEn,
  input logic              rdEn,
  input logic              unlock,
  input logic [DATA_W-1:0] rdData,
  input logic              clkEn
);
  logic acceptDiv, penShadow, unmapped;

  assign acceptDiv = wrEn && unlock && (addr == ADDR_W'(1));
  assign unmapped  = (addr != ADDR_W'(0)) && (addr != ADDR_W'(1)) &&
                     (addr != ADDR_W'(2)) && (addr != ADDR_W'(8));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          penShadow <= 1'b0;
    else if (acceptDiv) penShadow <= wrData[0];
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> rdData == '0); // R3
  AST_STATUS_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(2)) |=> rdData == '0); // R4
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unmapped) |=> rdData == '0); // R5
  AST_BYPASS_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !penShadow |-> clkEn); // R6
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && penShadow && !acceptDiv) |=> !clkEn); // R7
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (acceptDiv && wrData[0]) |=> !clkEn); // R10
endmodule

bind protected_clock_ctl pcc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_protected_clock_ctl.sv
module sim_protected_clock_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0, unlock = 1'b0;
  logic [7:0] rdData;
  logic       clkEn;
  int checks = 0, errors = 0;

  protected_clock_ctl u0 (.*);

  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int expRatio(input bit pen, input int code);
    if (!pen) return 1;
    if (code <= 5) return 2 << code;
    case (code)
      8: return 6; 9: return 10; 10: return 12; 11: return 24; 12: return 48;
      default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // starts at a negedge, returns at the next negedge
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic u);
    addr = a; wrData = d; wrEn = 1'b1; unlock = u;
    @(negedge clk);
    wrEn = 1'b0; unlock = 1'b0;
  endtask

  task automatic chkRead(input logic [3:0] a, input logic [7:0] exp, input string req);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    check(rdData == exp, req, rdData, exp);
    rdEn = 1'b0;
  endtask

  // j is the number of edges since the last restart (0 = just after it)
  task automatic chkCadence(input int ratio, input int startJ, input int cycles, input string req);
    bit ok = 1'b1;
    int badJ = 0;
    for (int j = startJ; j < startJ + cycles; j++) begin
      if (clkEn !== ((j % ratio) == ratio - 1) && ok) begin ok = 1'b0; badJ = j; end
      if (j < startJ + cycles - 1) @(negedge clk);
    end
    check(ok, req, badJ, ratio);
  endtask

  initial begin
    string tag;
    int r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chkRead(4'h0, 8'h00, "R1"); chkRead(4'h1, 8'h00, "R1");
    chkRead(4'h2, 8'h00, "R1"); chkRead(4'h8, 8'h00, "R1");
    chkCadence(1, 0, 5, "R1");

    // R2/R3: unlocked writes stored, locked writes dropped
    wr(4'h0, 8'hA5, 1'b1); chkRead(4'h0, 8'hA5, "R2");
    wr(4'h8, 8'h3C, 1'b1); chkRead(4'h8, 8'h3C, "R2");
    wr(4'h0, 8'h11, 1'b0); chkRead(4'h0, 8'hA5, "R2");
    wr(4'h8, 8'h22, 1'b0); chkRead(4'h8, 8'h3C, "R2");
    wr(4'h1, 8'hE1, 1'b0); chkRead(4'h1, 8'h00, "R2");
    // R3: read while unlock high is the same; idle cycle reads zero
    addr = 4'h0; rdEn = 1'b1; unlock = 1'b1;
    @(negedge clk);
    check(rdData == 8'hA5, "R3", rdData, 8'hA5);
    rdEn = 1'b0; unlock = 1'b0;
    @(negedge clk);
    check(rdData == 8'h00, "R3", rdData, 0);

    // R4: status ignores writes
    wr(4'h2, 8'hFF, 1'b1); chkRead(4'h2, 8'h00, "R4");
    wr(4'h2, 8'hFF, 1'b0); chkRead(4'h2, 8'h00, "R4");

    // R5: every unimplemented offset
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 1 || a == 2 || a == 8) continue;
      wr(4'(a), 8'hFF, 1'b1);
      chkRead(4'(a), 8'h00, "R5");
    end
    chkRead(4'h0, 8'hA5, "R5"); chkRead(4'h1, 8'h00, "R5"); chkRead(4'h8, 8'h3C, "R5");

    // R6..R9: full sweep of enable and code
    for (int pen = 0; pen < 2; pen++) begin
      for (int code = 0; code < 16; code++) begin
        r = expRatio(pen[0], code);
        if (!pen) tag = "R6";
        else if (code <= 5) tag = "R7";
        else if (code >= 8 && code <= 12) tag = "R8";
        else tag = "R9";
        wr(4'h1, {3'b000, 4'(code), pen[0]}, 1'b1);
        chkCadence(r, 0, 2 * r, tag);
        @(negedge clk);
        chkRead(4'h1, {3'b000, 4'(code), pen[0]}, "R2");
        chkRead(4'h2, 8'h00, "R4");
      end
    end

    // R10: restart on a cycle where clkEn is high (ratio 4 -> ratio 8)
    wr(4'h1, 8'h03, 1'b1);
    chkCadence(4, 0, 4, "R10");           // now at j=3, clkEn high
    check(clkEn == 1'b1, "R10", clkEn, 1);
    wr(4'h1, 8'h05, 1'b1);
    chkCadence(8, 0, 16, "R10");

    // R11: locked write mid-period leaves ratio 4 cadence intact
    wr(4'h1, 8'h03, 1'b1);
    @(negedge clk);                       // j=1
    wr(4'h1, 8'h01, 1'b0);                // now j=2
    chkCadence(4, 2, 12, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule